// File: doc/BRIEF.md
# Two-Cycle Dual-Port General Register File

This block holds the general-purpose registers of a small pipelined processor: fifteen 64-bit registers selected by a 4-bit identifier. It has two read ports and two write ports. Each port accepts a new request on every clock, so a pipeline can issue two reads and two writes each cycle without waiting.

Both directions take two cycles. A read presented in cycle M is sampled at the edge that ends M, and its data and valid flag are held in output registers through cycle M+1. A write presented in cycle N is captured at the edge that ends N and lands in the storage array at the edge that ends N+1. The array has no bypass path, so a value reaches a reader only when the read is issued two or more cycles after the write. The identifier 0xF names no register: reading it returns zero and writing it changes nothing. The outside hazard logic is responsible for stalling or forwarding around this window.

Top module: `gpr_file2c`

## Requirements
- R1: The data for a read presented in cycle M is the register's contents as of the end of cycle M, and it is held on the read data output throughout cycle M+1.
- R2: A read port's valid output is high in cycle M+1 exactly when that port's enable was high in cycle M. While the enable is low, the data output keeps its previous value.
- R3: A write presented in cycle N is committed at the edge that ends cycle N+1. A read presented in cycle N or N+1 returns the old value.
- R4: A read presented in cycle N+2 or later returns the value written in cycle N. The two write ports can update different registers in the same cycle.
- R5: When both write ports target the same register in the same cycle, the value on write port 1 is the one stored.
- R6: A read of identifier 0xF returns zero and still raises valid.
- R7: A write to identifier 0xF changes no register.
- R8: A synchronous active-high reset clears every register, every in-flight write and both read outputs, including valid, to zero.
- R9: Reads and writes can be issued on every cycle with no gap. Each result follows R1 to R7 independently of its neighbours.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd0_en | input | 1 | Read port 0 request |
| rd0_id | input | 4 | Read port 0 register identifier |
| rd1_en | input | 1 | Read port 1 request |
| rd1_id | input | 4 | Read port 1 register identifier |
| wr0_en | input | 1 | Write port 0 request |
| wr0_id | input | 4 | Write port 0 register identifier |
| wr0_data | input | 64 | Write port 0 value |
| wr1_en | input | 1 | Write port 1 request (wins on a collision) |
| wr1_id | input | 4 | Write port 1 register identifier |
| wr1_data | input | 64 | Write port 1 value |
| rd0_valid | output | 1 | Read port 0 data valid |
| rd0_data | output | 64 | Read port 0 data |
| rd1_valid | output | 1 | Read port 1 data valid |
| rd1_data | output | 64 | Read port 1 data |

## Verification
The assertions assume that every input is a known value at each rising edge and that reset is held high from time zero through at least one edge. They do not assume any spacing between a write and a later read, because stale reads are legal and are part of the specified behaviour. The stimulus changes inputs only on falling edges. Identifiers are drawn over the full 4-bit range, so 0xF and same-register write collisions occur often. Reset is driven by dedicated directed sequences, one of which sends a write just before reset so that the write is still in flight when reset arrives.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam int GPR_DATA_W = 64;
  localparam int GPR_ID_W   = 4;
  localparam int GPR_N_RD   = 2;
  localparam int GPR_N_WR   = 2;
endpackage

// File: rtl/gpr_wr_stage.sv
// First write cycle: capture each write request at the rising edge.
module gpr_wr_stage #(
  parameter int DATA_W = gpr_pkg::GPR_DATA_W,
  parameter int ID_W   = gpr_pkg::GPR_ID_W,
  parameter int N_WR   = gpr_pkg::GPR_N_WR
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i   [N_WR],
  input  logic [ID_W-1:0]   id_i   [N_WR],
  input  logic [DATA_W-1:0] data_i [N_WR],
  output logic              en_o   [N_WR],
  output logic [ID_W-1:0]   id_o   [N_WR],
  output logic [DATA_W-1:0] data_o [N_WR]
);
  for (genvar p = 0; p < N_WR; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (rst) begin
        en_o[p]   <= 1'b0;
        id_o[p]   <= '0;
        data_o[p] <= '0;
      end else begin
        en_o[p]   <= en_i[p];
        id_o[p]   <= id_i[p];
        data_o[p] <= data_i[p];
      end
    end
  end
endmodule

// File: rtl/gpr_store.sv
// Storage array: commits staged writes and exposes unregistered reads.
module gpr_store #(
  parameter int DATA_W = gpr_pkg::GPR_DATA_W,
  parameter int ID_W   = gpr_pkg::GPR_ID_W,
  parameter int N_WR   = gpr_pkg::GPR_N_WR,
  parameter int N_RD   = gpr_pkg::GPR_N_RD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              c_en   [N_WR],
  input  logic [ID_W-1:0]   c_id   [N_WR],
  input  logic [DATA_W-1:0] c_data [N_WR],
  input  logic [ID_W-1:0]   rd_id  [N_RD],
  output logic [DATA_W-1:0] rd_val [N_RD]
);
  localparam int          N_REGS  = (1 << ID_W) - 1;
  localparam logic [ID_W-1:0] NULL_ID = {ID_W{1'b1}};

  logic [DATA_W-1:0] regs [N_REGS];

  // Later ports are assigned last, so the highest-numbered port wins.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_REGS; i++) regs[i] <= '0;
    end else begin
      for (int p = 0; p < N_WR; p++) begin
        if (c_en[p] && c_id[p] != NULL_ID) regs[c_id[p]] <= c_data[p];
      end
    end
  end

  for (genvar r = 0; r < N_RD; r++) begin : g_rd
    always_comb begin
      if (rd_id[r] == NULL_ID) rd_val[r] = '0;
      else                     rd_val[r] = regs[rd_id[r]];
    end
  end

  // R4: an uncontested port-0 commit lands in the array.
  a_r4_commit_port0: assert property (@(posedge clk) disable iff (rst)
    (c_en[0] && c_id[0] != NULL_ID && !(c_en[1] && c_id[1] == c_id[0]))
    |=> regs[$past(c_id[0])] == $past(c_data[0]));

  // R5: on a collision the port-1 value is the one stored.
  a_r5_port1_wins: assert property (@(posedge clk) disable iff (rst)
    (c_en[0] && c_en[1] && c_id[0] == c_id[1] && c_id[1] != NULL_ID)
    |=> regs[$past(c_id[1])] == $past(c_data[1]));
endmodule

// File: rtl/gpr_rd_port.sv
// One read port: samples the array at the request edge and holds the result.
module gpr_rd_port #(
  parameter int DATA_W = gpr_pkg::GPR_DATA_W,
  parameter int ID_W   = gpr_pkg::GPR_ID_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic [DATA_W-1:0] arr_val_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  localparam logic [ID_W-1:0] NULL_ID = {ID_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= en_i;
      if (en_i) data_o <= arr_val_i;
    end
  end

  a_r2_valid_follows_en: assert property (@(posedge clk) disable iff (rst)
    en_i |=> valid_o);
  a_r2_idle_no_valid: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (!valid_o && $stable(data_o)));
  a_r6_null_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (en_i && id_i == NULL_ID) |=> (data_o == '0));
endmodule

// File: rtl/gpr_file2c.sv
module gpr_file2c #(
  parameter int DATA_W = gpr_pkg::GPR_DATA_W,
  parameter int ID_W   = gpr_pkg::GPR_ID_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd0_en,
  input  logic [ID_W-1:0]   rd0_id,
  input  logic              rd1_en,
  input  logic [ID_W-1:0]   rd1_id,
  input  logic              wr0_en,
  input  logic [ID_W-1:0]   wr0_id,
  input  logic [DATA_W-1:0] wr0_data,
  input  logic              wr1_en,
  input  logic [ID_W-1:0]   wr1_id,
  input  logic [DATA_W-1:0] wr1_data,
  output logic              rd0_valid,
  output logic [DATA_W-1:0] rd0_data,
  output logic              rd1_valid,
  output logic [DATA_W-1:0] rd1_data
);
  localparam int N_RD = 2;
  localparam int N_WR = 2;

  logic              w_en   [N_WR];
  logic [ID_W-1:0]   w_id   [N_WR];
  logic [DATA_W-1:0] w_data [N_WR];
  logic              s_en   [N_WR];
  logic [ID_W-1:0]   s_id   [N_WR];
  logic [DATA_W-1:0] s_data [N_WR];
  logic              r_en   [N_RD];
  logic [ID_W-1:0]   r_id   [N_RD];
  logic [DATA_W-1:0] r_val  [N_RD];
  logic              r_vld  [N_RD];
  logic [DATA_W-1:0] r_dat  [N_RD];

  always_comb begin
    w_en[0] = wr0_en; w_id[0] = wr0_id; w_data[0] = wr0_data;
    w_en[1] = wr1_en; w_id[1] = wr1_id; w_data[1] = wr1_data;
    r_en[0] = rd0_en; r_id[0] = rd0_id;
    r_en[1] = rd1_en; r_id[1] = rd1_id;
  end

  gpr_wr_stage #(.DATA_W(DATA_W), .ID_W(ID_W), .N_WR(N_WR)) u_wr_stage (
    .clk(clk), .rst(rst),
    .en_i(w_en), .id_i(w_id), .data_i(w_data),
    .en_o(s_en), .id_o(s_id), .data_o(s_data)
  );

  gpr_store #(.DATA_W(DATA_W), .ID_W(ID_W), .N_WR(N_WR), .N_RD(N_RD)) u_store (
    .clk(clk), .rst(rst),
    .c_en(s_en), .c_id(s_id), .c_data(s_data),
    .rd_id(r_id), .rd_val(r_val)
  );

  for (genvar r = 0; r < N_RD; r++) begin : g_rd
    gpr_rd_port #(.DATA_W(DATA_W), .ID_W(ID_W)) u_rd (
      .clk(clk), .rst(rst),
      .en_i(r_en[r]), .id_i(r_id[r]), .arr_val_i(r_val[r]),
      .valid_o(r_vld[r]), .data_o(r_dat[r])
    );
  end

  assign rd0_valid = r_vld[0];
  assign rd0_data  = r_dat[0];
  assign rd1_valid = r_vld[1];
  assign rd1_data  = r_dat[1];

  // R8: reset leaves both read outputs cleared.
  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> (!rd0_valid && !rd1_valid && rd0_data == '0 && rd1_data == '0));
endmodule

// File: tb/gpr_file2c_bench.sv
module gpr_file2c_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd0_en = 0, rd1_en = 0, wr0_en = 0, wr1_en = 0;
  logic [3:0]  rd0_id = 0, rd1_id = 0, wr0_id = 0, wr1_id = 0;
  logic [63:0] wr0_data = 0, wr1_data = 0;
  logic        rd0_valid, rd1_valid;
  logic [63:0] rd0_data, rd1_data;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpr_file2c u_gpr_file2c (
    .clk(clk), .rst(rst),
    .rd0_en(rd0_en), .rd0_id(rd0_id), .rd1_en(rd1_en), .rd1_id(rd1_id),
    .wr0_en(wr0_en), .wr0_id(wr0_id), .wr0_data(wr0_data),
    .wr1_en(wr1_en), .wr1_id(wr1_id), .wr1_data(wr1_data),
    .rd0_valid(rd0_valid), .rd0_data(rd0_data),
    .rd1_valid(rd1_valid), .rd1_data(rd1_data)
  );

  // Reference model
  logic [63:0] m_regs [15];
  logic        p_en [2];
  logic [3:0]  p_id [2];
  logic [63:0] p_dat [2];
  logic        e_vld [2];
  logic [63:0] e_dat [2];

  function automatic logic [63:0] m_read(logic [3:0] id);
    return (id == 4'hF) ? 64'h0 : m_regs[id];
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    rd0_en = 0; rd1_en = 0; wr0_en = 0; wr1_en = 0;
  endtask

  // One clock: update the model from the inputs now applied, then check.
  task automatic step();
    if (rst) begin
      for (int i = 0; i < 15; i++) m_regs[i] = '0;
      for (int p = 0; p < 2; p++) begin
        p_en[p] = 0; p_id[p] = 0; p_dat[p] = 0; e_vld[p] = 0; e_dat[p] = 0;
      end
    end else begin
      e_vld[0] = rd0_en; if (rd0_en) e_dat[0] = m_read(rd0_id);
      e_vld[1] = rd1_en; if (rd1_en) e_dat[1] = m_read(rd1_id);
      for (int p = 0; p < 2; p++)
        if (p_en[p] && p_id[p] != 4'hF) m_regs[p_id[p]] = p_dat[p];
      p_en[0] = wr0_en; p_id[0] = wr0_id; p_dat[0] = wr0_data;
      p_en[1] = wr1_en; p_id[1] = wr1_id; p_dat[1] = wr1_data;
    end
    @(posedge clk);
    @(negedge clk);
    chk("R2 valid0", {63'h0, rd0_valid}, {63'h0, e_vld[0]});
    chk("R2 valid1", {63'h0, rd1_valid}, {63'h0, e_vld[1]});
    chk("R9 data0", rd0_data, e_dat[0]);
    chk("R9 data1", rd1_data, e_dat[1]);
  endtask

  task automatic rd2(logic [3:0] a, logic [3:0] b);
    rd0_en = 1; rd0_id = a; rd1_en = 1; rd1_id = b;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1; idle();
    step(); step();
    chk("R8 reset valid", {63'h0, rd0_valid}, 64'h0);
    rst = 0;
    rd2(4'd3, 4'd14); step();
    chk("R8 reg3 after reset", rd0_data, 64'h0);
    chk("R8 reg14 after reset", rd1_data, 64'h0);

    // R3/R4: two ports, different registers, timing window
    idle();
    wr0_en = 1; wr0_id = 4'd2; wr0_data = 64'hAAAA_0000_1111_2222;
    wr1_en = 1; wr1_id = 4'd5; wr1_data = 64'hBBBB_3333_4444_5555;
    rd2(4'd2, 4'd5); step();
    chk("R3 same-cycle read old", rd0_data, 64'h0);
    idle(); rd2(4'd2, 4'd5); step();
    chk("R3 next-cycle read old 0", rd0_data, 64'h0);
    chk("R3 next-cycle read old 1", rd1_data, 64'h0);
    rd2(4'd2, 4'd5); step();
    chk("R4 read new port0 write", rd0_data, 64'hAAAA_0000_1111_2222);
    chk("R4 read new port1 write", rd1_data, 64'hBBBB_3333_4444_5555);
    chk("R1 valid with data", {63'h0, rd0_valid}, 64'h1);

    // R2: data held while idle
    idle(); step();
    chk("R2 data held", rd0_data, 64'hAAAA_0000_1111_2222);
    chk("R2 valid low", {63'h0, rd0_valid}, 64'h0);

    // R5: collision
    wr0_en = 1; wr0_id = 4'd7; wr0_data = 64'hC0C0;
    wr1_en = 1; wr1_id = 4'd7; wr1_data = 64'hD1D1;
    step(); idle(); step();
    rd2(4'd7, 4'd7); step();
    chk("R5 port1 wins", rd0_data, 64'hD1D1);

    // R6/R7: null identifier
    idle();
    wr0_en = 1; wr0_id = 4'hF; wr0_data = 64'hDEAD;
    wr1_en = 1; wr1_id = 4'hF; wr1_data = 64'hBEEF;
    step(); idle(); step();
    rd2(4'hF, 4'd2); step();
    chk("R6 null read zero", rd0_data, 64'h0);
    chk("R6 null read valid", {63'h0, rd0_valid}, 64'h1);
    chk("R7 null write no effect", rd1_data, 64'hAAAA_0000_1111_2222);
    idle();
    for (int i = 0; i < 15; i += 2) begin
      rd2(i[3:0], i[3:0] + 4'd1); step();
    end

    // R1: read in cycle N+2 exactly
    idle();
    wr0_en = 1; wr0_id = 4'd11; wr0_data = 64'h1234_5678_9ABC_DEF0;
    step(); idle(); rd2(4'd11, 4'd11); step();
    chk("R1 pre-commit value", rd0_data, 64'h0);
    rd2(4'd11, 4'd11); step();
    chk("R1 post-commit value", rd0_data, 64'h1234_5678_9ABC_DEF0);

    // R8: reset with a write in flight
    idle();
    wr0_en = 1; wr0_id = 4'd9; wr0_data = 64'hFACE;
    step();
    idle(); rst = 1; step();
    rst = 0; step();
    rd2(4'd9, 4'd11); step();
    chk("R8 in-flight write dropped", rd0_data, 64'h0);
    chk("R8 register cleared", rd1_data, 64'h0);

    // R9: random back-to-back traffic
    for (int n = 0; n < 3000; n++) begin
      rd0_en = $urandom_range(0, 3) != 0; rd0_id = 4'($urandom);
      rd1_en = $urandom_range(0, 3) != 0; rd1_id = 4'($urandom);
      wr0_en = $urandom_range(0, 1) == 1; wr0_id = 4'($urandom);
      wr1_en = $urandom_range(0, 1) == 1; wr1_id = 4'($urandom);
      wr0_data = {$urandom, $urandom};
      wr1_data = {$urandom, $urandom};
      step();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule